// File: doc/BRIEF.md
# Byte-Write Dual-Port RAM

This block is an on-chip RAM with two ports, each on its own clock. Every port has a port enable, one write-enable bit per byte lane, an address, write data and read data. Lanes are 8 bits wide, or 9 bits wide when each byte carries a parity bit that the RAM stores as plain data. A build-time switch selects one of two arrangements. In the symmetric arrangement both ports read and write. In the split arrangement port A only writes and port B only reads. In that case the word is normally twice as wide: for example 8 lanes of 9 bits, where the symmetric arrangement would use 4.

Each port sets its own read-during-write behaviour. The choices are: new data, old data, or output unchanged. The read word first lands in an output holding stage. A second, optional pipeline register can follow it. This register advances only when its clock enable is high. The holding stage and the register each have their own synchronous reset, and both load a per-port reset value. As a build option, one asynchronous clear input can instead drive both stages to zero at any time. When that option is chosen, the synchronous resets and the register clock enable are ignored.

In the symmetric arrangement a write may touch at most one lane. Any other nonzero enable pattern is flagged on an error output one cycle later. The write itself still takes place.

Top module: `dpbram_bw`

## Requirements
- R1: An enabled access samples the address at a clock edge, and the holding stage shows the result right after that edge. With the pipeline register fitted, the data reaches the port one edge later, provided the register's clock enable is high at that edge.
- R2: In new-data mode, an enabled access puts the stored word on the output, with every lane whose write-enable bit is set replaced by the incoming data.
- R3: In old-data mode, an enabled access puts the word stored before the edge on the output.
- R4: In output-unchanged mode, an enabled access with any write-enable bit set leaves the holding stage unchanged. An access with no bit set reads normally.
- R5: Write-enable bit i writes bits [i*LANE_W +: LANE_W] of the word. All other lanes keep their contents. LANE_W is 8 or 9.
- R6: In the symmetric arrangement, an enabled access whose write-enable has two or more bits set raises err_we_x for the following cycle. Otherwise err_we_x is low after the edge.
- R7: With its port enable low, a port writes nothing and its holding stage keeps its value.
- R8: Without the asynchronous option, a synchronous hold reset loads RST_VAL_x into the holding stage. This reset takes priority over the access.
- R9: Without the asynchronous option, the register reset loads RST_VAL_x into the pipeline register. With its clock enable low, the register holds its value.
- R10: With the asynchronous option, arst high clears the holding stage and the register to zero at once. The synchronous resets are ignored, and the register advances on every edge whatever its clock enable.
- R11: In the split arrangement, port A writes with any enable pattern and raises no flag, and rdata_a never loads from memory. Writes presented on port B are ignored.
- R12: Both ports share one storage array. A word written through one port is read back through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | LANES | Port A per-lane write enable |
| addr_a | input | $clog2(DEPTH) | Port A word address |
| wdata_a | input | LANES*LANE_W | Port A write data |
| rst_lat_a | input | 1 | Port A synchronous holding-stage reset |
| rst_reg_a | input | 1 | Port A synchronous pipeline-register reset |
| oce_a | input | 1 | Port A pipeline-register clock enable |
| rdata_a | output | LANES*LANE_W | Port A read data |
| err_we_a | output | 1 | Port A illegal write-enable flag |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | LANES | Port B per-lane write enable |
| addr_b | input | $clog2(DEPTH) | Port B word address |
| wdata_b | input | LANES*LANE_W | Port B write data |
| rst_lat_b | input | 1 | Port B synchronous holding-stage reset |
| rst_reg_b | input | 1 | Port B synchronous pipeline-register reset |
| oce_b | input | 1 | Port B pipeline-register clock enable |
| rdata_b | output | LANES*LANE_W | Port B read data |
| err_we_b | output | 1 | Port B illegal write-enable flag |
| arst | input | 1 | Asynchronous clear of both output stages (build option) |

## Verification
On every cycle, the assertions check the lane-pattern flag, output stability while a port is idle or writing in output-unchanged mode, the synchronous reset value, the asynchronous clear to zero, and the silent port A output in the split arrangement. Only the bench's scenarios can show that stored data is correct. That covers merged lanes in new-data mode, old words in old-data mode, writes seen from the opposite port, ignored port B writes in the split arrangement, and the pipeline register's timing. The bench shows these by comparing against a reference memory over random and directed traffic, and it never reads from both ports at an address being written.

// File: rtl/dpbram_pkg.sv
package dpbram_pkg;

    // Read-during-write behaviour of one port.
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

endpackage

// File: rtl/dpbram_store.sv
// Storage shared by both ports. Each lane keeps two banks, and each bank is
// written by one clock only. The stored word is the XOR of the two banks, so
// neither bank has more than one driver.
module dpbram_store #(
    parameter int  LANE_W = 9,
    parameter int  LANES  = 4,
    parameter int  DEPTH  = 512,
    localparam int W      = LANES * LANE_W,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic             clk_a,
    input  logic [LANES-1:0] wen_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [W-1:0]     wdata_a,
    output logic [W-1:0]     word_a,
    input  logic             clk_b,
    input  logic [LANES-1:0] wen_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [W-1:0]     wdata_b,
    output logic [W-1:0]     word_b
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] bank_a [DEPTH];
        logic [LANE_W-1:0] bank_b [DEPTH];

        always_ff @(posedge clk_a) begin
            if (wen_a[l]) begin
                bank_a[addr_a] <= wdata_a[l*LANE_W +: LANE_W] ^ bank_b[addr_a];
            end
        end

        always_ff @(posedge clk_b) begin
            if (wen_b[l]) begin
                bank_b[addr_b] <= wdata_b[l*LANE_W +: LANE_W] ^ bank_a[addr_b];
            end
        end

        assign word_a[l*LANE_W +: LANE_W] = bank_a[addr_a] ^ bank_b[addr_a];
        assign word_b[l*LANE_W +: LANE_W] = bank_a[addr_b] ^ bank_b[addr_b];
    end

endmodule

// File: rtl/dpbram_port.sv
// Per-port logic: write gating, read-during-write selection, the output
// holding stage, the optional pipeline register and the lane-pattern flag.
module dpbram_port
    import dpbram_pkg::*;
#(
    parameter int              LANE_W     = 9,
    parameter int              LANES      = 4,
    parameter wmode_e          MODE       = WM_WRITE_FIRST,
    parameter bit              WR_OK      = 1'b1,
    parameter bit              RD_OK      = 1'b1,
    parameter bit              CHK_ONEHOT = 1'b1,
    parameter bit              OUT_REG    = 1'b0,
    parameter bit              ASYNC_RST  = 1'b0,
    parameter logic [LANES*LANE_W-1:0] RST_VAL = '0,
    localparam int             W          = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             en,
    input  logic [LANES-1:0] we,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     stored,
    input  logic             rst_lat,
    input  logic             rst_reg,
    input  logic             oce,
    output logic [LANES-1:0] we_eff,
    output logic [W-1:0]     rdata,
    output logic             err_we
);

    logic [W-1:0] merged;
    logic [W-1:0] nxt;
    logic         load;
    logic [W-1:0] lat;
    logic [W-1:0] oreg;
    logic         err_q;
    logic [3:0]   unused_ctl;

    // Each build variant uses only some of the controls.
    assign unused_ctl = {arst, rst_lat, rst_reg, oce};

    assign we_eff = (WR_OK && en) ? we : '0;

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*LANE_W +: LANE_W] =
            we_eff[l] ? wdata[l*LANE_W +: LANE_W] : stored[l*LANE_W +: LANE_W];
    end

    always_comb begin
        load = 1'b0;
        nxt  = stored;
        unique case (MODE)
            WM_WRITE_FIRST: begin
                load = en;
                nxt  = merged;
            end
            WM_READ_FIRST: begin
                load = en;
            end
            WM_NO_CHANGE: begin
                load = en && (we_eff == '0);
            end
            default: begin
                load = 1'b0;
            end
        endcase
        if (!RD_OK) begin
            load = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        err_q <= CHK_ONEHOT && en && ((we & (we - LANES'(1))) != '0);
    end
    assign err_we = err_q;

    if (ASYNC_RST) begin : g_async
        always_ff @(posedge clk or posedge arst) begin
            if (arst) begin
                lat <= '0;
            end else if (load) begin
                lat <= nxt;
            end
        end
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or posedge arst) begin
                if (arst) begin
                    oreg <= '0;
                end else begin
                    oreg <= lat;
                end
            end
        end else begin : g_noreg
            assign oreg = '0;
        end
    end else begin : g_sync
        always_ff @(posedge clk) begin
            if (rst_lat) begin
                lat <= RST_VAL;
            end else if (load) begin
                lat <= nxt;
            end
        end
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst_reg) begin
                    oreg <= RST_VAL;
                end else if (oce) begin
                    oreg <= lat;
                end
            end
        end else begin : g_noreg
            assign oreg = '0;
        end
    end

    assign rdata = OUT_REG ? oreg : lat;

endmodule

// File: rtl/dpbram_bw.sv
module dpbram_bw
    import dpbram_pkg::*;
#(
    parameter bit     SDP       = 1'b0,
    parameter int     LANE_W    = 9,
    parameter int     LANES     = 4,
    parameter int     DEPTH     = 512,
    parameter wmode_e MODE_A    = WM_WRITE_FIRST,
    parameter wmode_e MODE_B    = WM_WRITE_FIRST,
    parameter bit     OUT_REG_A = 1'b0,
    parameter bit     OUT_REG_B = 1'b0,
    parameter bit     ASYNC_RST = 1'b0,
    parameter logic [LANES*LANE_W-1:0] RST_VAL_A = '0,
    parameter logic [LANES*LANE_W-1:0] RST_VAL_B = '0,
    localparam int    W         = LANES * LANE_W,
    localparam int    AW        = $clog2(DEPTH)
) (
    input  logic             clk_a,
    input  logic             en_a,
    input  logic [LANES-1:0] we_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [W-1:0]     wdata_a,
    input  logic             rst_lat_a,
    input  logic             rst_reg_a,
    input  logic             oce_a,
    output logic [W-1:0]     rdata_a,
    output logic             err_we_a,
    input  logic             clk_b,
    input  logic             en_b,
    input  logic [LANES-1:0] we_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [W-1:0]     wdata_b,
    input  logic             rst_lat_b,
    input  logic             rst_reg_b,
    input  logic             oce_b,
    output logic [W-1:0]     rdata_b,
    output logic             err_we_b,
    input  logic             arst
);

    localparam bit TDP = (SDP == 1'b0);

    logic [LANES-1:0] wen_a;
    logic [LANES-1:0] wen_b;
    logic [W-1:0]     word_a;
    logic [W-1:0]     word_b;

    dpbram_store #(
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk_a   (clk_a),
        .wen_a   (wen_a),
        .addr_a  (addr_a),
        .wdata_a (wdata_a),
        .word_a  (word_a),
        .clk_b   (clk_b),
        .wen_b   (wen_b),
        .addr_b  (addr_b),
        .wdata_b (wdata_b),
        .word_b  (word_b)
    );

    dpbram_port #(
        .LANE_W     (LANE_W),
        .LANES      (LANES),
        .MODE       (MODE_A),
        .WR_OK      (1'b1),
        .RD_OK      (TDP),
        .CHK_ONEHOT (TDP),
        .OUT_REG    (OUT_REG_A),
        .ASYNC_RST  (ASYNC_RST),
        .RST_VAL    (RST_VAL_A)
    ) u_port_a (
        .clk     (clk_a),
        .arst    (arst),
        .en      (en_a),
        .we      (we_a),
        .wdata   (wdata_a),
        .stored  (word_a),
        .rst_lat (rst_lat_a),
        .rst_reg (rst_reg_a),
        .oce     (oce_a),
        .we_eff  (wen_a),
        .rdata   (rdata_a),
        .err_we  (err_we_a)
    );

    dpbram_port #(
        .LANE_W     (LANE_W),
        .LANES      (LANES),
        .MODE       (MODE_B),
        .WR_OK      (TDP),
        .RD_OK      (1'b1),
        .CHK_ONEHOT (TDP),
        .OUT_REG    (OUT_REG_B),
        .ASYNC_RST  (ASYNC_RST),
        .RST_VAL    (RST_VAL_B)
    ) u_port_b (
        .clk     (clk_b),
        .arst    (arst),
        .en      (en_b),
        .we      (we_b),
        .wdata   (wdata_b),
        .stored  (word_b),
        .rst_lat (rst_lat_b),
        .rst_reg (rst_reg_b),
        .oce     (oce_b),
        .we_eff  (wen_b),
        .rdata   (rdata_b),
        .err_we  (err_we_b)
    );

endmodule

// File: rtl/dpbram_chk.sv
module dpbram_chk
    import dpbram_pkg::*;
#(
    parameter bit     SDP       = 1'b0,
    parameter int     LANES     = 4,
    parameter int     W         = 36,
    parameter wmode_e MODE_A    = WM_WRITE_FIRST,
    parameter bit     OUT_REG_A = 1'b0,
    parameter bit     ASYNC_RST = 1'b0,
    parameter logic [W-1:0] RST_VAL_A = '0
) (
    input logic             clk_a,
    input logic             arst,
    input logic             en_a,
    input logic [LANES-1:0] we_a,
    input logic             rst_lat_a,
    input logic [W-1:0]     rdata_a,
    input logic             err_we_a,
    input logic [W-1:0]     rdata_b
);

    // R6: several lanes in one symmetric-mode write raise the flag next cycle
    p_flag_set_r6: assert property (@(posedge clk_a) disable iff (arst)
        (!SDP && en_a && ((we_a & (we_a - LANES'(1))) != '0)) |=> err_we_a);

    // R6: legal patterns, idle cycles and the split arrangement leave it low
    p_flag_clear_r6: assert property (@(posedge clk_a) disable iff (arst)
        (SDP || !en_a || ((we_a & (we_a - LANES'(1))) == '0)) |=> !err_we_a);

    // R7: an idle port keeps its output
    p_idle_hold_r7: assert property (@(posedge clk_a) disable iff (arst)
        (!OUT_REG_A && !en_a && !rst_lat_a) |=> $stable(rdata_a));

    // R4: output-unchanged mode holds the output during a write
    p_nochange_r4: assert property (@(posedge clk_a) disable iff (arst)
        (MODE_A == WM_NO_CHANGE && !OUT_REG_A && !SDP && en_a && we_a != '0
         && !rst_lat_a) |=> $stable(rdata_a));

    // R8: the synchronous hold reset loads the reset value
    p_rstval_r8: assert property (@(posedge clk_a) disable iff (arst)
        (!ASYNC_RST && !OUT_REG_A && rst_lat_a) |=> (rdata_a == RST_VAL_A));

    // R10: the asynchronous clear forces both outputs to zero
    p_async_clear_r10: assert property (@(posedge clk_a)
        (ASYNC_RST && arst) |-> (rdata_a == '0 && rdata_b == '0));

    // R11: in the split arrangement port A never loads read data
    p_sdp_quiet_r11: assert property (@(posedge clk_a) disable iff (arst)
        (SDP && !OUT_REG_A && !rst_lat_a) |=> $stable(rdata_a));

endmodule

bind dpbram_bw dpbram_chk #(
    .SDP       (SDP),
    .LANES     (LANES),
    .W         (W),
    .MODE_A    (MODE_A),
    .OUT_REG_A (OUT_REG_A),
    .ASYNC_RST (ASYNC_RST),
    .RST_VAL_A (RST_VAL_A)
) u_chk (
    .clk_a     (clk_a),
    .arst      (arst),
    .en_a      (en_a),
    .we_a      (we_a),
    .rst_lat_a (rst_lat_a),
    .rdata_a   (rdata_a),
    .err_we_a  (err_we_a),
    .rdata_b   (rdata_b)
);

// File: tb/dpbram_bw_tb.sv
module dpbram_bw_tb;
    import dpbram_pkg::*;

    localparam logic [35:0] D_RSTA = 36'h9_ABCD_1234;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // ---------------- main instance: symmetric, 4 x 9-bit lanes ----------------
    logic        d_en_a = 0, d_rst_lat_a = 1, d_rst_reg_a = 0, d_oce_a = 0;
    logic [3:0]  d_we_a = 0;
    logic [8:0]  d_addr_a = 0;
    logic [35:0] d_wd_a = 0;
    logic [35:0] d_rd_a;
    logic        d_err_a;
    logic        d_en_b = 0, d_rst_lat_b = 1, d_rst_reg_b = 1, d_oce_b = 1;
    logic [3:0]  d_we_b = 0;
    logic [8:0]  d_addr_b = 0;
    logic [35:0] d_wd_b = 0;
    logic [35:0] d_rd_b;
    logic        d_err_b;
    logic        d_arst = 0;

    dpbram_bw #(
        .SDP(1'b0), .LANE_W(9), .LANES(4), .DEPTH(512),
        .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST),
        .OUT_REG_A(1'b0), .OUT_REG_B(1'b1), .ASYNC_RST(1'b0),
        .RST_VAL_A(D_RSTA), .RST_VAL_B('0)
    ) u_dut (
        .clk_a(clk), .en_a(d_en_a), .we_a(d_we_a), .addr_a(d_addr_a),
        .wdata_a(d_wd_a), .rst_lat_a(d_rst_lat_a), .rst_reg_a(d_rst_reg_a),
        .oce_a(d_oce_a), .rdata_a(d_rd_a), .err_we_a(d_err_a),
        .clk_b(clk), .en_b(d_en_b), .we_b(d_we_b), .addr_b(d_addr_b),
        .wdata_b(d_wd_b), .rst_lat_b(d_rst_lat_b), .rst_reg_b(d_rst_reg_b),
        .oce_b(d_oce_b), .rdata_b(d_rd_b), .err_we_b(d_err_b), .arst(d_arst)
    );

    // -------- async-clear instance: symmetric, 2 x 8-bit, A unchanged, B new ----
    logic        n_en_a = 0, n_rst_lat_a = 0, n_rst_reg_a = 0, n_oce_a = 0;
    logic [1:0]  n_we_a = 0;
    logic [3:0]  n_addr_a = 0;
    logic [15:0] n_wd_a = 0;
    logic [15:0] n_rd_a;
    logic        n_err_a;
    logic        n_en_b = 0, n_rst_lat_b = 0, n_rst_reg_b = 0, n_oce_b = 0;
    logic [1:0]  n_we_b = 0;
    logic [3:0]  n_addr_b = 0;
    logic [15:0] n_wd_b = 0;
    logic [15:0] n_rd_b;
    logic        n_err_b;
    logic        n_arst = 1;

    dpbram_bw #(
        .SDP(1'b0), .LANE_W(8), .LANES(2), .DEPTH(16),
        .MODE_A(WM_NO_CHANGE), .MODE_B(WM_WRITE_FIRST),
        .OUT_REG_A(1'b0), .OUT_REG_B(1'b1), .ASYNC_RST(1'b1),
        .RST_VAL_A(16'h5A5A), .RST_VAL_B(16'hA5A5)
    ) u_nc (
        .clk_a(clk), .en_a(n_en_a), .we_a(n_we_a), .addr_a(n_addr_a),
        .wdata_a(n_wd_a), .rst_lat_a(n_rst_lat_a), .rst_reg_a(n_rst_reg_a),
        .oce_a(n_oce_a), .rdata_a(n_rd_a), .err_we_a(n_err_a),
        .clk_b(clk), .en_b(n_en_b), .we_b(n_we_b), .addr_b(n_addr_b),
        .wdata_b(n_wd_b), .rst_lat_b(n_rst_lat_b), .rst_reg_b(n_rst_reg_b),
        .oce_b(n_oce_b), .rdata_b(n_rd_b), .err_we_b(n_err_b), .arst(n_arst)
    );

    // -------- split instance: A writes, B reads, 8 x 8-bit lanes ---------------
    logic        s_en_a = 0, s_rst_lat_a = 1, s_rst_reg_a = 0, s_oce_a = 0;
    logic [7:0]  s_we_a = 0;
    logic [5:0]  s_addr_a = 0;
    logic [63:0] s_wd_a = 0;
    logic [63:0] s_rd_a;
    logic        s_err_a;
    logic        s_en_b = 0, s_rst_lat_b = 1, s_rst_reg_b = 0, s_oce_b = 0;
    logic [7:0]  s_we_b = 0;
    logic [5:0]  s_addr_b = 0;
    logic [63:0] s_wd_b = 0;
    logic [63:0] s_rd_b;
    logic        s_err_b;
    logic        s_arst = 0;

    dpbram_bw #(
        .SDP(1'b1), .LANE_W(8), .LANES(8), .DEPTH(64),
        .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST),
        .OUT_REG_A(1'b0), .OUT_REG_B(1'b0), .ASYNC_RST(1'b0),
        .RST_VAL_A('0), .RST_VAL_B('0)
    ) u_sdp (
        .clk_a(clk), .en_a(s_en_a), .we_a(s_we_a), .addr_a(s_addr_a),
        .wdata_a(s_wd_a), .rst_lat_a(s_rst_lat_a), .rst_reg_a(s_rst_reg_a),
        .oce_a(s_oce_a), .rdata_a(s_rd_a), .err_we_a(s_err_a),
        .clk_b(clk), .en_b(s_en_b), .we_b(s_we_b), .addr_b(s_addr_b),
        .wdata_b(s_wd_b), .rst_lat_b(s_rst_lat_b), .rst_reg_b(s_rst_reg_b),
        .oce_b(s_oce_b), .rdata_b(s_rd_b), .err_we_b(s_err_b), .arst(s_arst)
    );

    // ---------------- reference model for u_dut ----------------
    logic [35:0] ref_m [512];
    logic [35:0] m_lat_a, m_lat_b, m_reg_b;
    logic        m_err_a, m_err_b;

    function automatic logic [35:0] mrg(input logic [35:0] o, input logic [35:0] n,
                                        input logic [3:0] w);
        logic [35:0] r;
        r = o;
        for (int l = 0; l < 4; l++) begin
            if (w[l]) r[l*9 +: 9] = n[l*9 +: 9];
        end
        return r;
    endfunction

    function automatic logic multi(input logic [3:0] w);
        return (w & (w - 4'd1)) != 4'd0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Called at a falling edge with inputs set; checks after the next rising edge.
    task automatic d_step(input string ta, input string tb);
        logic [35:0] oa, ob, nla, nlb, nrb;
        logic nea, neb;
        oa  = ref_m[d_addr_a];
        ob  = ref_m[d_addr_b];
        nla = d_rst_lat_a ? D_RSTA : (d_en_a ? mrg(oa, d_wd_a, d_we_a) : m_lat_a);
        nlb = d_rst_lat_b ? 36'd0 : (d_en_b ? ob : m_lat_b);
        nrb = d_rst_reg_b ? 36'd0 : (d_oce_b ? m_lat_b : m_reg_b);
        nea = d_en_a && multi(d_we_a);
        neb = d_en_b && multi(d_we_b);
        if (d_en_a) ref_m[d_addr_a] = mrg(oa, d_wd_a, d_we_a);
        if (d_en_b) ref_m[d_addr_b] = mrg(ob, d_wd_b, d_we_b);
        @(posedge clk);
        #1;
        m_lat_a = nla; m_lat_b = nlb; m_reg_b = nrb; m_err_a = nea; m_err_b = neb;
        chk({ta, " port A data"}, 64'(d_rd_a), 64'(m_lat_a));
        chk({tb, " port B data"}, 64'(d_rd_b), 64'(m_reg_b));
        chk("R6 flag A", 64'(d_err_a), 64'(m_err_a));
        chk("R6 flag B", 64'(d_err_b), 64'(m_err_b));
        @(negedge clk);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);

        // reset state: hold stage to RST_VAL, register cleared
        d_step("R8 reset", "R9 reset");
        d_rst_lat_a = 0; d_rst_lat_b = 0; d_rst_reg_b = 0;

        // async instance is held in clear since time zero
        chk("R10 clear A", 64'(n_rd_a), 64'd0);
        chk("R10 clear B", 64'(n_rd_b), 64'd0);

        // fill all words through port A (all lanes: flagged, still written)
        for (int i = 0; i < 512; i++) begin
            d_en_a = 1; d_we_a = 4'hF; d_addr_a = 9'(i);
            d_wd_a = 36'({$urandom, $urandom});
            d_step("R5 fill", "R1 fill");
        end
        d_en_a = 0; d_we_a = 0;

        // random traffic, distinct addresses on the two ports
        for (int i = 0; i < 400; i++) begin
            d_en_a      = ($urandom % 4) != 0;
            d_we_a      = 4'($urandom);
            d_addr_a    = 9'($urandom % 16);
            d_wd_a      = 36'({$urandom, $urandom});
            d_en_b      = ($urandom % 4) != 0;
            d_we_b      = 4'($urandom);
            d_addr_b    = d_addr_a ^ 9'(1 + $urandom % 15);
            d_wd_b      = 36'({$urandom, $urandom});
            d_rst_lat_a = ($urandom % 20) == 0;
            d_rst_lat_b = ($urandom % 20) == 0;
            d_rst_reg_b = ($urandom % 20) == 0;
            d_oce_b     = ($urandom % 3) != 0;
            d_step("R2 random", "R3 random");
        end
        d_rst_lat_a = 0; d_rst_lat_b = 0; d_rst_reg_b = 0; d_oce_b = 1;
        d_en_a = 0; d_en_b = 0; d_we_a = 0; d_we_b = 0;

        // R12: one lane written through A, read back through B
        d_en_a = 1; d_we_a = 4'b0010; d_addr_a = 9'd40; d_wd_a = 36'h0_1234_5678;
        d_step("R12 write A", "R12 idle B");
        d_en_a = 0; d_we_a = 0;
        d_en_b = 1; d_addr_b = 9'd40;
        d_step("R12 idle A", "R12 read B");
        d_en_b = 0;
        d_step("R1 idle A", "R1 register B");

        // R7: a disabled port neither writes nor updates its output
        d_en_a = 0; d_we_a = 4'hF; d_addr_a = 9'd40; d_wd_a = '1;
        d_step("R7 disabled A", "R7 idle B");
        d_en_a = 1; d_we_a = 0;
        d_step("R7 readback A", "R7 idle B");
        d_en_a = 0;

        // R9: register holds with its enable low, then resets
        d_en_b = 1; d_addr_b = 9'd41; d_oce_b = 0;
        d_step("R9 idle A", "R9 hold");
        d_en_b = 0;
        d_step("R9 idle A", "R9 hold");
        d_rst_reg_b = 1;
        d_step("R9 idle A", "R9 register reset");
        d_rst_reg_b = 0; d_oce_b = 1;

        // ---------------- u_nc: async clear, unchanged / new-data modes ----------
        n_arst = 0;
        @(negedge clk);
        n_en_b = 1; n_we_b = 2'b11; n_addr_b = 4'd3; n_wd_b = 16'hBEEF; n_oce_b = 0;
        tick();
        chk("R6 multi-lane flag", 64'(n_err_b), 64'd1);
        chk("R10 register one edge behind", 64'(n_rd_b), 64'd0);
        @(negedge clk);
        n_en_b = 0; n_we_b = 0;
        tick();
        chk("R2 R10 register advances with enable low", 64'(n_rd_b), 64'hBEEF);
        @(negedge clk);
        n_en_a = 1; n_we_a = 0; n_addr_a = 4'd3;
        tick();
        chk("R12 read on A", 64'(n_rd_a), 64'hBEEF);
        @(negedge clk);
        n_we_a = 2'b01; n_wd_a = 16'h0011;
        tick();
        chk("R4 output held during write", 64'(n_rd_a), 64'hBEEF);
        chk("R6 one-hot not flagged", 64'(n_err_a), 64'd0);
        @(negedge clk);
        n_we_a = 0; n_rst_lat_a = 1;
        tick();
        chk("R5 R10 lane write, sync reset ignored", 64'(n_rd_a), 64'hBE11);
        @(negedge clk);
        n_en_a = 0; n_rst_lat_a = 0;
        n_arst = 1;
        #1;
        chk("R10 async clear A", 64'(n_rd_a), 64'd0);
        chk("R10 async clear B", 64'(n_rd_b), 64'd0);
        @(negedge clk);
        n_arst = 0;

        // ---------------- u_sdp: split arrangement ----------------
        s_rst_lat_a = 1; s_rst_lat_b = 1;
        tick();
        chk("R8 split reset A", 64'(s_rd_a), 64'd0);
        chk("R8 split reset B", 64'(s_rd_b), 64'd0);
        @(negedge clk);
        s_rst_lat_a = 0; s_rst_lat_b = 0;
        s_en_a = 1; s_we_a = 8'hFF; s_addr_a = 6'd5; s_wd_a = 64'h0123_4567_89AB_CDEF;
        tick();
        chk("R11 multi-lane write not flagged", 64'(s_err_a), 64'd0);
        chk("R11 port A output quiet", s_rd_a, 64'd0);
        @(negedge clk);
        s_en_a = 0; s_we_a = 0;
        s_en_b = 1; s_we_b = 8'hFF; s_addr_b = 6'd5; s_wd_b = 64'hFFFF_0000_FFFF_0000;
        tick();
        chk("R11 read through B", s_rd_b, 64'h0123_4567_89AB_CDEF);
        @(negedge clk);
        s_we_b = 0;
        tick();
        chk("R11 port B write ignored", s_rd_b, 64'h0123_4567_89AB_CDEF);
        @(negedge clk);
        s_en_b = 0;
        s_en_a = 1; s_we_a = 8'h0F; s_wd_a = 64'hAAAA_AAAA_5555_5555;
        tick();
        chk("R11 port A still quiet", s_rd_a, 64'd0);
        @(negedge clk);
        s_en_a = 0; s_we_a = 0;
        s_en_b = 1;
        tick();
        chk("R5 split lane merge", s_rd_b, 64'h0123_4567_5555_5555);
        @(negedge clk);
        s_en_b = 0;

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule